// File: doc/BRIEF.md
# Periodic Cell Leak Unit with Memory Arbiter

This block owns the signed state memory of an event-driven convolution array and applies a global forgetting action to it. A programmable period counter raises a leak tick. Each tick starts a sweep that walks the whole array. The sweep pulls every cell toward zero by a programmable step, and it never lets a cell pass through zero. A second agent, the event convolution engine, reaches the same single-port memory through a request/grant port.

The engine always has priority. The sweep reads a cell only in a cycle in which the engine is not requesting. Each cell is handled as a read followed, in the very next cycle, by the write-back of the leaked value. The memory is not given away between those two cycles. A paused sweep resumes at the first cell it has not yet processed. A tick that arrives while a sweep is running is stored as a single pending sweep. A zero period or a zero step turns leaking off.

Top module: `cell_leak_unit`

## Requirements
- R1: With a nonzero period P and a nonzero step, a leak tick occurs once every P cycles. No cell changes before the first tick.
- R2: When the period is 0 or the step is 0, no tick occurs and every cell keeps its value.
- R3: A sweep visits each address once, in ascending order from 0 to CELLS-1. Each visit is a memory read followed in the next cycle by a write-back to the same address. No engine grant is given in that write-back cycle.
- R4: A positive cell becomes value minus step, or 0 if its value is not larger than the step.
- R5: A negative cell becomes value plus step, or 0 if its magnitude is not larger than the step. Zero stays zero, and the most negative value is handled without overflow.
- R6: conv_gnt is high exactly when conv_req is high and the cycle is not a sweep write-back cycle. The sweep never reads in a cycle in which conv_req is high.
- R7: While the engine holds the memory, the sweep address holds still. The sweep then continues, so each cell is leaked exactly once per tick, whatever the engine traffic.
- R8: Ticks that arrive during a sweep are merged into one pending sweep. That sweep starts after the current one ends.
- R9: A granted engine write stores conv_wdata at conv_addr at that clock edge. A granted engine read shows the cell on conv_rdata from the following cycle.
- R10: After reset no sweep is running or pending and the period counter is cleared, so conv_gnt follows conv_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| leak_period | input | PER_W | Cycles between leak ticks; 0 disables |
| leak_amount | input | AMT_W | Magnitude removed per sweep; 0 disables |
| conv_req | input | 1 | Engine memory request |
| conv_we | input | 1 | Engine request is a write |
| conv_addr | input | $clog2(CELLS) | Engine cell address |
| conv_wdata | input | CELL_W | Engine write value, two's complement |
| conv_gnt | output | 1 | Engine access taken this cycle |
| conv_rdata | output | CELL_W | Cell read data, one cycle after a granted read |

## Verification
A wrong sweep address, phase or pending flag first shows at the ports as a grant that is withheld or given in the wrong cycle. The reference model catches this in the same cycle. A wrong leak step or a skipped or doubled visit shows up as a wrong value on conv_rdata, at the first engine read of that cell after the sweep. A lost or extra sweep shows as cell values that are off by a whole step. Mixing heavy engine traffic with short periods pushes the pause, resume and merge paths through the same checks.

// File: rtl/leak_pkg.sv
package leak_pkg;
  typedef enum logic {
    PH_READ  = 1'b0,
    PH_WRITE = 1'b1
  } sweep_phase_t;
endpackage

// File: rtl/leak_period_timer.sv
module leak_period_timer #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PER_W-1:0] period,
  input  logic             step_nz,
  output logic             tick
);
  logic [PER_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (period == '0 || !step_nz) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= period - 1'b1) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/leak_sweep_ctrl.sv
module leak_sweep_ctrl
  import leak_pkg::*;
#(
  parameter int CELLS  = 64,
  parameter int ADDR_W = $clog2(CELLS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              conv_req,
  output logic              sweep_rd,
  output logic              sweep_wr,
  output logic [ADDR_W-1:0] sweep_addr,
  output logic              sweep_busy
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(CELLS - 1);

  sweep_phase_t phase;
  logic         pending;

  assign sweep_wr = (phase == PH_WRITE);
  assign sweep_rd = sweep_busy && (phase == PH_READ) && !conv_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_READ;
      sweep_busy <= 1'b0;
      pending    <= 1'b0;
      sweep_addr <= '0;
    end else begin
      if (!sweep_busy && pending) begin
        sweep_busy <= 1'b1;
        pending    <= tick;
      end else begin
        pending <= pending | tick;
      end
      if (phase == PH_WRITE) begin
        phase <= PH_READ;
        if (sweep_addr == LAST) begin
          sweep_busy <= 1'b0;
          sweep_addr <= '0;
        end else begin
          sweep_addr <= sweep_addr + 1'b1;
        end
      end else if (sweep_rd) begin
        phase <= PH_WRITE;
      end
    end
  end
endmodule

// File: rtl/leak_step.sv
module leak_step #(
  parameter int CELL_W = 8,
  parameter int AMT_W  = 7
) (
  input  logic [CELL_W-1:0] cell_in,
  input  logic [AMT_W-1:0]  amount,
  output logic [CELL_W-1:0] cell_out
);
  localparam int CMP_W = ((CELL_W > AMT_W) ? CELL_W : AMT_W) + 1;

  logic              neg;
  logic [CELL_W-1:0] mag;
  logic [CMP_W-1:0]  mag_e, amt_e, rem;
  logic [CELL_W-1:0] new_mag;

  always_comb begin
    neg      = cell_in[CELL_W-1];
    mag      = neg ? (~cell_in + 1'b1) : cell_in;
    mag_e    = CMP_W'(mag);
    amt_e    = CMP_W'(amount);
    rem      = (mag_e > amt_e) ? (mag_e - amt_e) : '0;
    new_mag  = rem[CELL_W-1:0];
    cell_out = neg ? (~new_mag + 1'b1) : new_mag;
  end
endmodule

// File: rtl/leak_cell_ram.sv
module leak_cell_ram #(
  parameter int CELLS  = 64,
  parameter int CELL_W = 8,
  parameter int ADDR_W = $clog2(CELLS)
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CELL_W-1:0] wdata,
  output logic [CELL_W-1:0] rdata
);
  logic [CELL_W-1:0] mem [CELLS];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/cell_leak_unit.sv
module cell_leak_unit #(
  parameter int CELLS  = 64,
  parameter int CELL_W = 8,
  parameter int PER_W  = 16,
  parameter int AMT_W  = 7,
  localparam int ADDR_W = $clog2(CELLS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PER_W-1:0]  leak_period,
  input  logic [AMT_W-1:0]  leak_amount,
  input  logic              conv_req,
  input  logic              conv_we,
  input  logic [ADDR_W-1:0] conv_addr,
  input  logic [CELL_W-1:0] conv_wdata,
  output logic              conv_gnt,
  output logic [CELL_W-1:0] conv_rdata
);
  logic              tick;
  logic              sweep_rd, sweep_wr, sweep_busy;
  logic [ADDR_W-1:0] sweep_addr;
  logic              ram_en, ram_we;
  logic [ADDR_W-1:0] ram_addr;
  logic [CELL_W-1:0] ram_wdata, ram_q, leaked;

  leak_period_timer #(.PER_W(PER_W)) u_timer (
    .clk(clk), .rst(rst), .period(leak_period),
    .step_nz(|leak_amount), .tick(tick)
  );

  leak_sweep_ctrl #(.CELLS(CELLS), .ADDR_W(ADDR_W)) u_sweep (
    .clk(clk), .rst(rst), .tick(tick), .conv_req(conv_req),
    .sweep_rd(sweep_rd), .sweep_wr(sweep_wr),
    .sweep_addr(sweep_addr), .sweep_busy(sweep_busy)
  );

  leak_step #(.CELL_W(CELL_W), .AMT_W(AMT_W)) u_step (
    .cell_in(ram_q), .amount(leak_amount), .cell_out(leaked)
  );

  // Engine wins every cycle except the write-back half of a sweep visit.
  assign conv_gnt  = conv_req && !sweep_wr;
  assign ram_en    = conv_gnt || sweep_rd || sweep_wr;
  assign ram_we    = conv_gnt ? conv_we : sweep_wr;
  assign ram_addr  = conv_gnt ? conv_addr : sweep_addr;
  assign ram_wdata = conv_gnt ? conv_wdata : leaked;

  leak_cell_ram #(.CELLS(CELLS), .CELL_W(CELL_W), .ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .en(ram_en), .we(ram_we), .addr(ram_addr),
    .wdata(ram_wdata), .rdata(ram_q)
  );

  assign conv_rdata = ram_q;
endmodule

// File: rtl/leak_unit_checker.sv
module leak_unit_checker #(
  parameter int CELL_W = 8,
  parameter int PER_W  = 16,
  parameter int AMT_W  = 7,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [PER_W-1:0]  leak_period,
  input logic [AMT_W-1:0]  leak_amount,
  input logic              conv_req,
  input logic              conv_gnt,
  input logic              tick,
  input logic              sweep_rd,
  input logic              sweep_wr,
  input logic              sweep_busy,
  input logic [ADDR_W-1:0] sweep_addr,
  input logic [CELL_W-1:0] ram_q,
  input logic [CELL_W-1:0] ram_wdata
);
  assert_disabled_no_tick_R2: assert property (@(posedge clk) disable iff (rst)
    (leak_period == '0 || leak_amount == '0) |=> !tick);

  assert_write_follows_read_R3: assert property (@(posedge clk) disable iff (rst)
    sweep_wr |-> $past(sweep_rd));

  assert_no_grant_in_write_R3: assert property (@(posedge clk) disable iff (rst)
    sweep_wr |-> !conv_gnt);

  assert_positive_no_cross_R4: assert property (@(posedge clk) disable iff (rst)
    (sweep_wr && !ram_q[CELL_W-1]) |->
      (!ram_wdata[CELL_W-1] && ($signed(ram_wdata) <= $signed(ram_q))));

  assert_negative_no_cross_R5: assert property (@(posedge clk) disable iff (rst)
    (sweep_wr && ram_q[CELL_W-1]) |->
      (($signed(ram_wdata) <= 0) && ($signed(ram_wdata) >= $signed(ram_q))));

  assert_grant_needs_request_R6: assert property (@(posedge clk) disable iff (rst)
    conv_gnt |-> conv_req);

  assert_sweep_yields_R6: assert property (@(posedge clk) disable iff (rst)
    sweep_rd |-> !conv_req);

  assert_paused_addr_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (sweep_busy && $past(sweep_busy) && !$past(sweep_wr)) |-> $stable(sweep_addr));
endmodule

bind cell_leak_unit leak_unit_checker #(
  .CELL_W(CELL_W), .PER_W(PER_W), .AMT_W(AMT_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .leak_period(leak_period), .leak_amount(leak_amount),
  .conv_req(conv_req), .conv_gnt(conv_gnt), .tick(tick),
  .sweep_rd(sweep_rd), .sweep_wr(sweep_wr), .sweep_busy(sweep_busy),
  .sweep_addr(sweep_addr), .ram_q(ram_q), .ram_wdata(ram_wdata)
);

// File: tb/tb_cell_leak_unit.sv
module tb_cell_leak_unit;
  localparam int N = 64;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [15:0]       leak_period = '0;
  logic [6:0]        leak_amount = '0;
  logic              conv_req = 1'b0, conv_we = 1'b0;
  logic [5:0]        conv_addr = '0;
  logic [7:0]        conv_wdata = '0;
  logic              conv_gnt;
  logic [7:0]        conv_rdata;

  int checks = 0, errors = 0;
  bit done = 0;

  cell_leak_unit dut (
    .clk(clk), .rst(rst), .leak_period(leak_period), .leak_amount(leak_amount),
    .conv_req(conv_req), .conv_we(conv_we), .conv_addr(conv_addr),
    .conv_wdata(conv_wdata), .conv_gnt(conv_gnt), .conv_rdata(conv_rdata)
  );

  always #5 clk = ~clk;

  function automatic int leakv(int v, int a);
    if (v > 0) return (v > a) ? v - a : 0;
    if (v < 0) return (-v > a) ? v + a : 0;
    return 0;
  endfunction

  function automatic int pat(int i);
    case (i % 8)
      0: return 20;
      1: return -20;
      2: return 3;
      3: return -3;
      4: return 127;
      5: return -128;
      6: return 0;
      default: return i * 3 - 90;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // Behavioural reference: timer, pending flag, sweep position, memory.
  int m_cnt, m_addr;
  bit m_tick, m_pend, m_act, m_wr, m_rdchk;
  int m_mem [N];
  int m_q;
  bit g, srd, swr, tk, act_old;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_addr = 0; m_tick = 0; m_pend = 0; m_act = 0; m_wr = 0; m_rdchk = 0;
    end else begin
      g = conv_req && !m_wr;
      srd = m_act && !m_wr && !conv_req;
      swr = m_wr;
      m_rdchk = g && !conv_we;
      if (g) begin
        m_q = m_mem[conv_addr];
        if (conv_we) m_mem[conv_addr] = int'($signed(conv_wdata));
      end else if (srd) begin
        m_q = m_mem[m_addr];
      end else if (swr) begin
        m_mem[m_addr] = leakv(m_q, int'(leak_amount));
      end
      tk = m_tick;
      if (leak_period == 0 || leak_amount == 0) begin m_cnt = 0; m_tick = 0; end
      else if (m_cnt >= int'(leak_period) - 1) begin m_cnt = 0; m_tick = 1; end
      else begin m_cnt++; m_tick = 0; end
      act_old = m_act;
      if (!act_old && m_pend) begin m_act = 1; m_pend = tk; end
      else m_pend = m_pend | tk;
      if (swr) begin
        m_wr = 0;
        if (m_addr == N - 1) begin m_act = 0; m_addr = 0; end
        else m_addr++;
      end else if (srd) m_wr = 1;
    end
  end

  always @(negedge clk) begin
    #2;
    if (!rst && !done) begin
      chk("R6/R3 grant", int'(conv_gnt), int'(conv_req && !m_wr));
      if (m_rdchk) chk("R9 read data", int'($signed(conv_rdata)), m_q);
    end
  end

  task automatic conv_op(input bit we, input int addr, input int d, output int rd);
    @(negedge clk);
    conv_req = 1'b1; conv_we = we; conv_addr = 6'(addr); conv_wdata = 8'(d);
    #1;
    while (!conv_gnt) begin @(negedge clk); #1; end
    @(negedge clk);
    #1;
    rd = int'($signed(conv_rdata));
    conv_req = 1'b0; conv_we = 1'b0;
  endtask

  task automatic fill();
    int rd;
    for (int i = 0; i < N; i++) conv_op(1'b1, i, pat(i), rd);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int rd;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #1 chk("R10 idle grant", int'(conv_gnt), 0);
    conv_req = 1'b1;
    #1 chk("R10 grant follows request", int'(conv_gnt), 1);
    conv_req = 1'b0;

    // R2: zero period, then zero step
    fill();
    leak_period = 16'd0; leak_amount = 7'd5; idle(300);
    leak_period = 16'd10; leak_amount = 7'd0; idle(300);
    for (int i = 0; i < N; i++) begin conv_op(1'b0, i, 0, rd); chk("R2 unchanged", rd, pat(i)); end
    leak_period = 16'd0;

    // R1, R4, R5: one tick, one sweep, step 5
    leak_amount = 7'd5; leak_period = 16'd200;
    idle(150);
    conv_op(1'b0, 0, 0, rd); chk("R1 before tick", rd, 20);
    idle(220);
    leak_period = 16'd0;
    idle(200);
    for (int i = 0; i < N; i++) begin
      conv_op(1'b0, i, 0, rd);
      if (pat(i) > 0) chk("R4 positive leak", rd, leakv(pat(i), 5));
      else chk("R5 negative or zero leak", rd, leakv(pat(i), 5));
    end

    // R7: engine traffic during a sweep, each cell leaked once
    fill();
    leak_amount = 7'd2; leak_period = 16'd100;
    idle(105);
    leak_period = 16'd0;
    for (int k = 0; k < 60; k++) conv_op(1'b0, k, 0, rd);
    idle(300);
    for (int i = 0; i < N; i++) begin conv_op(1'b0, i, 0, rd); chk("R7 leaked once", rd, leakv(pat(i), 2)); end

    // R8: ticks faster than a sweep, merged into one pending sweep
    fill();
    leak_amount = 7'd1; leak_period = 16'd20;
    idle(700);
    leak_period = 16'd0;
    idle(400);
    for (int i = 0; i < N; i++) begin conv_op(1'b0, i, 0, rd); chk("R8 merged ticks", rd, m_mem[i]); end
    conv_op(1'b0, 4, 0, rd);
    checks++;
    if (rd < 127 - 8 || rd > 127 - 4) begin
      errors++;
      $display("FAIL R8 sweep count: got %0d expected 119..123", rd);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule